// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block takes one floating-point operand that has already been unpacked into a class code, a sign, an unbiased exponent and a normalised mantissa, and turns it into a signed two's-complement integer. The mantissa holds its leading one explicitly at the most significant bit. Three extra tail bits (guard, round, sticky) carry precision lost by whatever stage produced the operand. The conversion always chops toward zero and ignores any rounding mode used elsewhere in the datapath. Each result comes with two per-operation flags: inexact, when fractional bits were dropped, and invalid, when the value cannot be represented.

An operand is presented with `in_valid` and appears on the registered outputs one clock later together with `out_valid`. When no operand is presented, the outputs keep their last values. Out-of-range values, infinities and NaNs saturate to a pattern chosen by the sign. The signed range is asymmetric, so the most negative integer converts exactly.

Top module: `float_to_int_trunc`

## Requirements
- R1: Class code 0 (zero) produces result 0 with inexact and invalid both low, whatever the sign, exponent, mantissa and tail bits are.
- R2: Class code 1 (number) with an exponent from 0 to INT_W-1 produces the integer part of 1.f x 2^exp. A negative sign returns the two's-complement negation of that magnitude.
- R3: A number with a negative exponent produces result 0, never a negated zero pattern, with inexact high and invalid low.
- R4: For an in-range number, inexact is high exactly when a mantissa bit below the integer part or any of the three tail bits is nonzero. Tail bits are ordered guard, round, sticky from MSB to LSB, and each of them counts.
- R5: No increment is ever applied. A magnitude of 2.75 gives 2, and -2.75 gives -2.
- R6: A number whose exponent is INT_W (32) or larger is an overflow.
- R7: A negative magnitude of exactly 2^31 converts to 0x80000000 without invalid. A positive magnitude of 2^31 overflows, and so does a negative magnitude above 2^31.
- R8: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 are always overflows.
- R9: On any overflow, invalid is high and inexact is low, even when bits were lost. The result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1.
- R10: `out_valid` rises one clock after an accepted `in_valid` and is low one clock after a cycle with `in_valid` low. Result and flags do not change in that idle cycle.
- R11: During reset, `out_valid`, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign of operand, 1 = negative |
| in_exp | input | EXP_W (10) | Unbiased exponent, two's complement |
| in_mant | input | MANT_W (32) | Mantissa with leading one at the MSB |
| in_tail | input | 3 | Guard, round, sticky (MSB to LSB) |
| out_valid | output | 1 | Registered result valid |
| out_result | output | INT_W (32) | Signed integer result |
| out_inexact | output | 1 | Fraction discarded on this conversion |
| out_invalid | output | 1 | Overflow, infinity or NaN on this conversion |

## Verification
The bench uses the default parameters: a 32-bit mantissa, a 32-bit integer and a 10-bit exponent. With these, exponent 31 places the whole mantissa in the integer part, so the exact boundary at 2^31 and its neighbours can be set directly. The 10-bit exponent also covers values far beyond 32 and below zero, which exercises both saturation and zero-flush. A behavioural model works the expected values out by right shifts on 64-bit integers, and its result is compared on every clock against mixed directed and pseudo-random operands, some with gaps in `in_valid`.

// File: rtl/fti_pkg.sv
package fti_pkg;

    typedef enum logic [2:0] {
        FCLS_ZERO = 3'd0,
        FCLS_NUM  = 3'd1,
        FCLS_INF  = 3'd2,
        FCLS_QNAN = 3'd3,
        FCLS_SNAN = 3'd4
    } fcls_e;

endpackage

// File: rtl/fti_align.sv
// Places the integer part of 1.f x 2^exp into an INT_W-bit magnitude and
// reports whether anything below the binary point was discarded.
module fti_align #(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 10,
    parameter int INT_W  = 32
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [2:0]        tail_i,
    output logic [INT_W-1:0]  mag_o,
    output logic              lost_o,
    output logic              too_big_o
);
    localparam int WIDE_W = MANT_W + INT_W;
    localparam int SH_W   = $clog2(INT_W + 1);
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

    logic              exp_neg;
    logic              in_range;
    logic [SH_W-1:0]   shamt;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        exp_neg   = exp_i[EXP_W-1];
        too_big_o = !exp_neg && ($signed(exp_i) >= EXP_LIM);
        in_range  = !exp_neg && !too_big_o;
        // exponent e puts e+1 mantissa bits above the binary point
        shamt     = SH_W'(exp_i) + SH_W'(1);
        wide      = {{INT_W{1'b0}}, mant_i} << shamt;
        if (in_range) begin
            mag_o  = wide[WIDE_W-1:MANT_W];
            lost_o = (|wide[MANT_W-1:0]) | (|tail_i);
        end else begin
            mag_o  = '0;
            lost_o = exp_neg ? ((|mant_i) | (|tail_i)) : 1'b0;
        end
    end
endmodule

// File: rtl/fti_range.sv
// Decides representability, applies the sign and picks saturation values.
module fti_range
    import fti_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [2:0]       class_i,
    input  logic             sign_i,
    input  logic [INT_W-1:0] mag_i,
    input  logic             lost_i,
    input  logic             too_big_i,
    output logic [INT_W-1:0] result_o,
    output logic             inexact_o,
    output logic             invalid_o
);
    localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

    logic mag_ovf;
    logic ovf;

    always_comb begin
        // negative side reaches one step further than the positive side
        mag_ovf = sign_i ? (mag_i > HALF) : (mag_i >= HALF);
        case (class_i)
            FCLS_ZERO: ovf = 1'b0;
            FCLS_NUM:  ovf = too_big_i | mag_ovf;
            default:   ovf = 1'b1;
        endcase

        if (class_i == FCLS_ZERO) begin
            result_o  = '0;
            inexact_o = 1'b0;
            invalid_o = 1'b0;
        end else if (ovf) begin
            result_o  = sign_i ? HALF : ~HALF;
            inexact_o = 1'b0;
            invalid_o = 1'b1;
        end else begin
            result_o  = sign_i ? (~mag_i + INT_W'(1)) : mag_i;
            inexact_o = lost_i;
            invalid_o = 1'b0;
        end
    end
endmodule

// File: rtl/float_to_int_trunc.sv
module float_to_int_trunc
    import fti_pkg::*;
#(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 10,
    parameter int INT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_class,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic [2:0]        in_tail,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_result,
    output logic              out_inexact,
    output logic              out_invalid
);
    localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

    typedef struct packed {
        logic             valid;
        logic [INT_W-1:0] result;
        logic             inexact;
        logic             invalid;
    } conv_state_t;

    conv_state_t st_d, st_q;

    logic [INT_W-1:0] mag_w;
    logic             lost_w;
    logic             too_big_w;
    logic [INT_W-1:0] res_w;
    logic             nx_w;
    logic             nv_w;

    fti_align #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W),
        .INT_W  (INT_W)
    ) u_align (
        .exp_i     (in_exp),
        .mant_i    (in_mant),
        .tail_i    (in_tail),
        .mag_o     (mag_w),
        .lost_o    (lost_w),
        .too_big_o (too_big_w)
    );

    fti_range #(
        .INT_W (INT_W)
    ) u_range (
        .class_i   (in_class),
        .sign_i    (in_sign),
        .mag_i     (mag_w),
        .lost_i    (lost_w),
        .too_big_i (too_big_w),
        .result_o  (res_w),
        .inexact_o (nx_w),
        .invalid_o (nv_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result  = res_w;
            st_d.inexact = nx_w;
            st_d.invalid = nv_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_result  = st_q.result;
    assign out_inexact = st_q.inexact;
    assign out_invalid = st_q.invalid;

    AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == FCLS_ZERO |=> out_result == '0 && !out_inexact && !out_invalid); // R1

    AST_NEG_EXP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == FCLS_NUM && in_exp[EXP_W-1] |=> out_result == '0 && out_inexact && !out_invalid); // R3

    AST_BIG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == FCLS_NUM && !in_exp[EXP_W-1] && $signed(in_exp) >= EXP_LIM |=> out_invalid); // R6

    AST_NONNUM_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class != FCLS_ZERO && in_class != FCLS_NUM |=> out_invalid); // R8

    AST_SAT_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_invalid |-> !out_inexact && (out_result == HALF || out_result == ~HALF)); // R9

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_result) && $stable(out_inexact) && $stable(out_invalid)); // R10
endmodule

// File: tb/float_to_int_trunc_bench.sv
module float_to_int_trunc_bench;
    localparam int MANT_W = 32;
    localparam int EXP_W  = 10;
    localparam int INT_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [2:0]        in_class;
    logic              in_sign;
    logic [EXP_W-1:0]  in_exp;
    logic [MANT_W-1:0] in_mant;
    logic [2:0]        in_tail;
    logic              out_valid;
    logic [INT_W-1:0]  out_result;
    logic              out_inexact;
    logic              out_invalid;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    logic        e_valid;
    logic [31:0] e_res;
    logic        e_nx;
    logic        e_nv;

    always #10 clk = ~clk;

    float_to_int_trunc #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W),
        .INT_W  (INT_W)
    ) u_float_to_int_trunc (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_class    (in_class),
        .in_sign     (in_sign),
        .in_exp      (in_exp),
        .in_mant     (in_mant),
        .in_tail     (in_tail),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_inexact (out_inexact),
        .out_invalid (out_invalid)
    );

    function automatic void model(input logic [2:0] c, input bit s, input int e,
                                  input logic [31:0] m, input logic [2:0] t,
                                  output logic [31:0] r, output logic nx, output logic nv);
        longint mag;
        bit     lost;
        bit     ovf;
        mag  = 0;
        lost = 1'b0;
        ovf  = 1'b0;
        if (c == 3'd0) begin
            r = 32'd0; nx = 1'b0; nv = 1'b0;
            return;
        end
        if (c != 3'd1) ovf = 1'b1;
        else if (e >= 32) ovf = 1'b1;
        else if (e < 0) begin
            mag  = 0;
            lost = (m != 0) || (t != 0);
        end else begin
            mag  = longint'(m) >> (31 - e);
            lost = ((longint'(m) & ((longint'(1) << (31 - e)) - 1)) != 0) || (t != 0);
            if (s ? (mag > 64'sd2147483648) : (mag >= 64'sd2147483648)) ovf = 1'b1;
        end
        if (ovf) begin
            r = s ? 32'h8000_0000 : 32'h7FFF_FFFF; nx = 1'b0; nv = 1'b1;
        end else begin
            r = s ? 32'(-mag) : 32'(mag); nx = lost; nv = 1'b0;
        end
    endfunction

    task automatic check(input string tag);
        n_checks++;
        if (out_valid !== e_valid || out_result !== e_res ||
            out_inexact !== e_nx || out_invalid !== e_nv) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b res=%h nx=%0b nv=%0b, expected valid=%0b res=%h nx=%0b nv=%0b",
                     tag, out_valid, out_result, out_inexact, out_invalid,
                     e_valid, e_res, e_nx, e_nv);
        end
    endtask

    task automatic step(input bit v, input logic [2:0] c, input bit s, input int e,
                        input logic [31:0] m, input logic [2:0] t, input string tag);
        in_valid = v;
        in_class = c;
        in_sign  = s;
        in_exp   = EXP_W'(e);
        in_mant  = m;
        in_tail  = t;
        if (v) model(c, s, e, m, t, e_res, e_nx, e_nv);
        e_valid = v;
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_class = 3'd1; in_sign = 1'b1;
        in_exp = '0; in_mant = 32'hFFFF_FFFF; in_tail = 3'b111;
        e_valid = 1'b0; e_res = 32'd0; e_nx = 1'b0; e_nv = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 reset state");
        rst_n = 1'b1;

        step(1, 3'd0, 1, 17, 32'hDEAD_BEEF, 3'b111, "R1 zero class ignores fields");
        step(1, 3'd1, 0, 0, 32'h8000_0000, 3'b000, "R2 one");
        step(1, 3'd1, 0, 2, 32'hA000_0000, 3'b000, "R2 five");
        step(1, 3'd1, 1, 2, 32'hA000_0000, 3'b000, "R2 minus five");
        step(1, 3'd1, 0, 30, 32'hFFFF_FFFE, 3'b000, "R2 largest positive");
        step(1, 3'd1, 0, 1, 32'hB000_0000, 3'b000, "R5 2.75 truncates");
        step(1, 3'd1, 1, 1, 32'hB000_0000, 3'b000, "R5 -2.75 truncates");
        step(1, 3'd1, 0, -1, 32'h8000_0000, 3'b000, "R3 half flushes");
        step(1, 3'd1, 1, -3, 32'hC000_0000, 3'b000, "R3 negative small flushes");
        step(1, 3'd1, 0, 30, 32'hC000_0000, 3'b000, "R4 exact no inexact");
        step(1, 3'd1, 0, 30, 32'hC000_0000, 3'b001, "R4 sticky sets inexact");
        step(1, 3'd1, 1, 31, 32'h8000_0000, 3'b100, "R4 guard sets inexact");
        step(1, 3'd1, 0, 32, 32'h8000_0000, 3'b000, "R6 exponent 32 positive");
        step(1, 3'd1, 1, 32, 32'h8000_0000, 3'b000, "R6 exponent 32 negative");
        step(1, 3'd1, 0, 300, 32'hF000_0000, 3'b000, "R6 huge exponent");
        step(1, 3'd1, 1, 31, 32'h8000_0000, 3'b000, "R7 minus 2^31 exact");
        step(1, 3'd1, 0, 31, 32'h8000_0000, 3'b000, "R7 plus 2^31 overflows");
        step(1, 3'd1, 1, 31, 32'h8000_0001, 3'b000, "R7 below minus 2^31 overflows");
        step(1, 3'd1, 0, 40, 32'h8000_0001, 3'b010, "R9 overflow clears inexact");
        step(1, 3'd2, 0, 0, 32'h8000_0000, 3'b000, "R8 plus infinity");
        step(1, 3'd2, 1, 0, 32'h8000_0000, 3'b000, "R8 minus infinity");
        step(1, 3'd3, 0, 5, 32'hC000_0000, 3'b001, "R8 quiet NaN");
        step(1, 3'd4, 1, 5, 32'hA000_0000, 3'b000, "R8 signalling NaN");
        step(1, 3'd6, 0, 5, 32'h8000_0000, 3'b000, "R8 unused class");
        step(1, 3'd1, 0, 3, 32'hF800_0000, 3'b000, "R2 before idle");
        step(0, 3'd1, 1, 7, 32'h8000_0000, 3'b111, "R10 idle holds");
        step(0, 3'd2, 0, 0, 32'h8000_0000, 3'b000, "R10 idle holds again");
        step(1, 3'd1, 1, 4, 32'h9000_0000, 3'b000, "R10 resume");

        for (int i = 0; i < 400; i++) begin
            int          r;
            logic [2:0]  c;
            r = int'($urandom % 8);
            c = (r < 4) ? 3'd1 : 3'(r);
            if (r == 4) c = 3'd0;
            step(($urandom % 5) != 0, c, bit'($urandom % 2),
                 int'($urandom % 48) - 6, $urandom | 32'h8000_0000,
                 3'($urandom % 8), "R2 mixed stream");
        end

        finish_run();
    end
endmodule